// File: doc/BRIEF.md
# Cascadable Two-Stage Operand Register

This block is the input pipeline for one 30-bit operand of an arithmetic slice. A static parameter picks the operand's source. The source is either the direct input from the fabric or the cascade input from the slice before it. The chosen value then passes through zero, one or two register stages. Each stage has its own load enable.

The block produces three results:
- a 25-bit operand for the multiplier or pre-adder;
- the full 30-bit value as the upper field of a 48-bit adder operand;
- a 30-bit cascade output that feeds the next slice in a chain.

A run-time mode bit lets the multiplier operand come from the first register stage while the adder field still comes from the last stage. This suits designs that need a shorter latency on the multiply path. Downstream arithmetic is not part of this block.

Top module: `opnd_cascade_pipe`

## Requirements
- R1: With parameter `SRC_CASCADE` = 1 the operand source is `casc_in`; with 0 it is `fab_in`.
- R2: With `STAGES` = 0, `wide_opnd` and `casc_out` equal the selected source in the same cycle, and `mul_opnd` equals its bits [24:0]. Enables, mode and reset have no effect.
- R3: With `STAGES` = 2, the first stage loads the source on a clock edge when `ld_first` is 1. The second stage loads the first stage's value on an edge when `ld_second` is 1. `wide_opnd` shows the second stage, so with both enables held at 1 the latency is two cycles.
- R4: With `STAGES` = 1, the second stage loads the source directly on an edge when `ld_second` is 1, and `wide_opnd` shows it one cycle later.
- R5: A stage whose enable is 0 keeps its value. The two enables act independently.
- R6: With `STAGES` of 1 or 2, `mul_tap_early` = 1 makes `mul_opnd` show the first stage and `mul_tap_early` = 0 makes it show the second stage. The bit acts combinationally on the output.
- R7: `mul_opnd` is bits [24:0] of the selected stage value; `wide_opnd` carries all 30 bits.
- R8: `casc_out` always equals the last active stage, the same value as `wide_opnd`.
- R9: `rst_n` = 0 on a clock edge clears both stages to zero, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fab_in | input | 30 | Direct operand from fabric logic |
| casc_in | input | 30 | Operand from the previous slice's cascade output |
| ld_first | input | 1 | Load enable of the first register stage |
| ld_second | input | 1 | Load enable of the second register stage |
| mul_tap_early | input | 1 | 1: multiplier operand from first stage |
| casc_out | output | 30 | Cascade operand toward the next slice |
| mul_opnd | output | 25 | Multiplier / pre-adder operand |
| wide_opnd | output | 30 | Upper field of the 48-bit adder operand |

## Verification
When there are no stages, all three outputs follow the source in the same cycle. With stages, a value captured at one edge is due at the outputs just after that edge, and a second stage adds one more edge. The mode bit changes `mul_opnd` without any clock edge. The bench drives inputs on the falling edge and checks one nanosecond later. It compares against a model that updates at each rising edge from the inputs held across that edge, so every check lands in the exact cycle a result is due. Three instances, with zero, one and two stages, run against the same stimulus while it sweeps every combination of the two enables and the mode bit, with periodic resets.

// File: rtl/opnd_pkg.sv
// Package opnd_pkg
// Shared constants for the operand pipeline: default operand widths and
// the legal range of the stage-count parameter.
package opnd_pkg;
    localparam int unsigned OPND_W_DEF = 30;
    localparam int unsigned MUL_W_DEF  = 25;
    localparam int unsigned MAX_STAGES = 2;
endpackage

// File: rtl/opnd_src_sel.sv
// Module opnd_src_sel
// Static choice of operand source: fabric input or cascade input.
// Assumes SRC_CASCADE is fixed at build time; the unused input is sunk.
module opnd_src_sel #(
    parameter int unsigned OPND_W      = 30,
    parameter bit          SRC_CASCADE = 1'b0
) (
    input  logic [OPND_W-1:0] fab_in,
    input  logic [OPND_W-1:0] casc_in,
    output logic [OPND_W-1:0] src_out
);
    logic unused_src;

    // Pick the source named by the parameter; the other is left unused.
    generate
        if (SRC_CASCADE) begin : g_casc
            assign src_out    = casc_in;
            assign unused_src = ^fab_in;
        end else begin : g_fab
            assign src_out    = fab_in;
            assign unused_src = ^casc_in;
        end
    endgenerate
endmodule

// File: rtl/opnd_stage.sv
// Module opnd_stage
// One operand register with a load enable and a synchronous active-low
// clear that takes priority over the enable. Assumes a single clock.
module opnd_stage #(
    parameter int unsigned OPND_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [OPND_W-1:0] d,
    output logic [OPND_W-1:0] q
);
    // Clear on reset, else load when enabled, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

    AST_STAGE_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R9
    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q)); // R5
    AST_STAGE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d))); // R3
endmodule

// File: rtl/opnd_tap_sel.sv
// Module opnd_tap_sel
// Chooses the multiplier operand: the early (first-stage) value when the
// mode bit asks for it and a first stage exists, else the last stage.
// Truncates to the multiplier width.
module opnd_tap_sel #(
    parameter int unsigned OPND_W    = 30,
    parameter int unsigned MUL_W     = 25,
    parameter bit          HAS_EARLY = 1'b1
) (
    input  logic              tap_early,
    input  logic [OPND_W-1:0] early_val,
    input  logic [OPND_W-1:0] last_val,
    output logic [MUL_W-1:0]  mul_val
);
    logic unused_tap;

    // Mode bit only matters when a first stage exists.
    generate
        if (HAS_EARLY) begin : g_tap
            assign mul_val    = tap_early ? early_val[MUL_W-1:0] : last_val[MUL_W-1:0];
            assign unused_tap = ^{early_val[OPND_W-1:MUL_W], last_val[OPND_W-1:MUL_W]};
        end else begin : g_notap
            assign mul_val    = last_val[MUL_W-1:0];
            assign unused_tap = ^{tap_early, early_val, last_val[OPND_W-1:MUL_W]};
        end
    endgenerate
endmodule

// File: rtl/opnd_cascade_pipe.sv
// Module opnd_cascade_pipe (top)
// Input pipeline for one operand of an arithmetic slice: static source
// select, 0/1/2 register stages with independent enables, a mode bit that
// taps the first stage for the multiplier, and a cascade output taken from
// the last active stage. Assumes STAGES is 0, 1 or 2.
module opnd_cascade_pipe #(
    parameter int unsigned OPND_W      = opnd_pkg::OPND_W_DEF,
    parameter int unsigned MUL_W       = opnd_pkg::MUL_W_DEF,
    parameter int unsigned STAGES      = 2,
    parameter bit          SRC_CASCADE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPND_W-1:0] fab_in,
    input  logic [OPND_W-1:0] casc_in,
    input  logic              ld_first,
    input  logic              ld_second,
    input  logic              mul_tap_early,
    output logic [OPND_W-1:0] casc_out,
    output logic [MUL_W-1:0]  mul_opnd,
    output logic [OPND_W-1:0] wide_opnd
);
    localparam bit HAS_REGS = (STAGES != 0);
    localparam bit CHAINED  = (STAGES == opnd_pkg::MAX_STAGES);

    logic [OPND_W-1:0] src_val;
    logic [OPND_W-1:0] first_q;
    logic [OPND_W-1:0] second_d;
    logic [OPND_W-1:0] second_q;
    logic [OPND_W-1:0] last_val;
    logic [OPND_W-1:0] early_val;
    logic              unused_top;

    opnd_src_sel #(.OPND_W(OPND_W), .SRC_CASCADE(SRC_CASCADE)) src_i (
        .fab_in (fab_in),
        .casc_in(casc_in),
        .src_out(src_val)
    );

    opnd_stage #(.OPND_W(OPND_W)) first_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (ld_first),
        .d    (src_val),
        .q    (first_q)
    );

    opnd_stage #(.OPND_W(OPND_W)) second_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (ld_second),
        .d    (second_d),
        .q    (second_q)
    );

    // Wire stage inputs and output taps according to the stage count.
    generate
        if (CHAINED) begin : g_two
            assign second_d   = first_q;
            assign last_val   = second_q;
            assign early_val  = first_q;
            assign unused_top = 1'b0;
        end else if (HAS_REGS) begin : g_one
            assign second_d   = src_val;
            assign last_val   = second_q;
            assign early_val  = first_q;
            assign unused_top = 1'b0;
        end else begin : g_zero
            assign second_d   = src_val;
            assign last_val   = src_val;
            assign early_val  = src_val;
            assign unused_top = ^{first_q, second_q, ld_first, ld_second, rst_n};
        end
    endgenerate

    opnd_tap_sel #(.OPND_W(OPND_W), .MUL_W(MUL_W), .HAS_EARLY(HAS_REGS)) tap_i (
        .tap_early(mul_tap_early),
        .early_val(early_val),
        .last_val (last_val),
        .mul_val  (mul_opnd)
    );

    // Adder field and cascade output both come from the last active stage.
    assign wide_opnd = last_val;
    assign casc_out  = last_val;

    generate
        if (HAS_REGS) begin : g_chk
            AST_EARLY_TAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                (mul_tap_early && $past(ld_first) && $past(rst_n))
                |-> (mul_opnd == $past(src_val[MUL_W-1:0]))); // R6
        end else begin : g_chk0
            // Zero stages: outputs follow the source with no clock in between.
            always_comb begin
                AST_COMB_FOLLOWS: assert (casc_out == src_val || $isunknown(src_val)); // R2
            end
        end
    endgenerate
endmodule

// File: tb/opnd_cascade_pipe_tb.sv
`timescale 1ns/1ps
module opnd_cascade_pipe_tb_top;
    localparam int OW = 30;
    localparam int MW = 25;
    localparam int N_CYC = 480;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [OW-1:0] fab = '0;
    logic [OW-1:0] casc = '0;
    logic          ce1 = 1'b0;
    logic          ce2 = 1'b0;
    logic          mode = 1'b0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    logic [OW-1:0] co0, wo0, co1, wo1, co2, wo2;
    logic [MW-1:0] mo0, mo1, mo2;

    always #5 clk = ~clk;

    // Zero stages, fabric source.
    opnd_cascade_pipe #(.STAGES(0), .SRC_CASCADE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .fab_in(fab), .casc_in(casc),
        .ld_first(ce1), .ld_second(ce2), .mul_tap_early(mode),
        .casc_out(co0), .mul_opnd(mo0), .wide_opnd(wo0));
    // One stage, cascade source.
    opnd_cascade_pipe #(.STAGES(1), .SRC_CASCADE(1'b1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .fab_in(fab), .casc_in(casc),
        .ld_first(ce1), .ld_second(ce2), .mul_tap_early(mode),
        .casc_out(co1), .mul_opnd(mo1), .wide_opnd(wo1));
    // Two stages, fabric source.
    opnd_cascade_pipe #(.STAGES(2), .SRC_CASCADE(1'b0)) dut2_i (
        .clk(clk), .rst_n(rst_n), .fab_in(fab), .casc_in(casc),
        .ld_first(ce1), .ld_second(ce2), .mul_tap_early(mode),
        .casc_out(co2), .mul_opnd(mo2), .wide_opnd(wo2));

    task automatic chk(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Model state: first/second stage of the 1-stage and 2-stage instances.
    logic [OW-1:0] a1, b1, a2, b2;

    initial begin
        logic prev_rst;
        logic prev_hold;
        string sfx;
        logic [OW-1:0] na1, nb1, na2, nb2, e1, e2;
        repeat (2) @(posedge clk);
        @(negedge clk);
        a1 = '0; b1 = '0; a2 = '0; b2 = '0;
        prev_rst = 1'b1;
        prev_hold = 1'b0;
        for (int i = 0; i < N_CYC; i++) begin
            logic [31:0] h;
            logic [2:0]  c;
            h = (i * 32'h9E3779B1) ^ (i << 7);
            c = 3'(i % 8);
            if (i >= 240 && i < 300) fab = OW'(1) << (i % OW);
            else if (i >= 300 && i < 320) fab = '1;
            else fab = h[OW-1:0];
            casc = ~h[OW-1:0] ^ 30'h2AA5_5A5A;
            ce1  = c[0];
            ce2  = c[1];
            mode = c[2];
            rst_n = ((i % 23) != 22);
            #1;
            sfx = prev_rst ? " R9" : (prev_hold ? " R5" : "");
            // Zero stages: same-cycle follow of the fabric input.
            chk({"R2 wide", sfx}, wo0, fab);
            chk({"R7 R2 mul", sfx}, OW'(mo0), OW'(fab[MW-1:0]));
            chk({"R8 R2 casc", sfx}, co0, fab);
            // One stage, cascade source.
            chk({"R4 R1 wide", sfx}, wo1, b1);
            e1 = mode ? a1 : b1;
            chk({"R6 R7 mul1", sfx}, OW'(mo1), OW'(e1[MW-1:0]));
            chk({"R8 casc1", sfx}, co1, b1);
            // Two stages, fabric source.
            chk({"R3 wide2", sfx}, wo2, b2);
            e2 = mode ? a2 : b2;
            chk({"R6 R7 mul2", sfx}, OW'(mo2), OW'(e2[MW-1:0]));
            chk({"R8 casc2", sfx}, co2, b2);
            // Next state from the inputs held across the coming edge.
            if (!rst_n) begin
                na1 = '0; nb1 = '0; na2 = '0; nb2 = '0;
            end else begin
                na1 = ce1 ? casc : a1;
                nb1 = ce2 ? casc : b1;
                na2 = ce1 ? fab : a2;
                nb2 = ce2 ? a2 : b2;
            end
            prev_rst  = !rst_n;
            prev_hold = !ce1 || !ce2;
            @(posedge clk);
            a1 = na1; b1 = nb1; a2 = na2; b2 = nb2;
            @(negedge clk);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule